// File: doc/BRIEF.md
# Prefix-Addressed Tuner Control Register File

This block holds the control registers of a satellite tuner and sits behind a byte-oriented serial port. The port is a plain stream of transaction markers: a start pulse, one byte-valid strobe per data byte, and a stop pulse. There is no address byte. The upper bits of the first data byte choose one of six even/odd register pairs, numbered 2/3 through 12/13. That byte is kept whole as the content of the even register of the pair. An optional second byte lands in the odd register.

The block presents the whole register image to the analog side, along with a registered set of decoded fields: a 15-bit divider, two bandwidth codes, a charge-pump code, a reference-divider code and a power-down flag. A separate status request returns one byte that carries a power-on-reset flag and a synchronised copy of an external lock input.

Top module: `tuner_regfile`

## Requirements
- R1: After reset, registers 2 to 13 hold 00, 00, 80, 00, C0, 20, DB, 30, E1, F5, F0, 28 (hex). `cfg_image` places register 2+k at bits 8k+7:8k.
- R2: The first byte selects its pair by prefix: bit7=0 gives 2/3, bits7:6=10 give 4/5, bits7:4=1100 give 6/7, 1101 give 8/9, 1110 give 10/11 and 1111 give 12/13.
- R3: The first byte of a transaction is written, all eight bits, into the even register of the selected pair.
- R4: The second byte of a transaction is written into the odd register of the same pair.
- R5: A transaction with exactly one byte leaves the odd register of the pair and all other registers unchanged.
- R6: A third or later byte in the same transaction changes no register.
- R7: A start followed by a stop with no bytes changes no register. A byte strobe outside a start/stop bracket also changes no register.
- R8: A status request pulse gives `status_valid` high on the next cycle. `status_data` bit 7 is the power-on-reset flag, bit 6 is the lock flag, and bits 5:0 are zero.
- R9: The power-on-reset flag is 1 after reset. A stop that ends a transaction with at least one byte clears it. It stays 0 until the next reset.
- R10: The lock flag follows `lock_in` through a two-stage synchroniser. A status read issued three or more cycles after a change of `lock_in` reports the new value.
- R11: The decoded outputs are registered copies of fields of the register file:
  - `divider` = {reg2[6:0], reg3}
  - `filt_code` = reg7[6:1]
  - `ratio_code` = reg13[6:2]
  - `power_down` = reg13[7]
  - `pump_code` = reg5[6:5]
  - `refdiv_code` = reg5[4:0]

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Asynchronous lock indication from the synthesiser |
| xfer_start | input | 1 | Opens a write transaction |
| byte_valid | input | 1 | Qualifies `byte_data` within a transaction |
| byte_data | input | 8 | Data byte |
| xfer_stop | input | 1 | Closes a write transaction |
| status_req | input | 1 | Requests the status byte |
| status_valid | output | 1 | Status byte present |
| status_data | output | 8 | Status byte |
| cfg_image | output | 96 | Full register image, registers 2 to 13 |
| divider | output | 15 | Synthesiser divider |
| filt_code | output | 6 | Baseband filter code |
| ratio_code | output | 5 | Bandwidth ratio code |
| pump_code | output | 2 | Charge-pump code |
| refdiv_code | output | 5 | Reference-divider code |
| power_down | output | 1 | Power-down flag |

## Verification
The stimulus writes two-byte transactions to every pair. First bytes are chosen on each prefix boundary, so a decoder that cuts one prefix length wrong lands on the wrong pair. One-byte and three-byte transactions show whether the odd register is touched only by a genuine second byte, and whether a trailing byte spills anywhere. Empty transactions and stray strobes outside a bracket tell a sequencer that gates on the bracket from one that listens all the time. Status reads taken before and after the first write, and around changes of the lock input, separate the power-on-reset flag from the lock path and check the bit positions of both.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 12;
  localparam int NUM_PAIRS = NUM_REGS / 2;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int PAIR_W    = IDX_W - 1;
  localparam int IMG_W     = REG_W * NUM_REGS;
  localparam int DIV_W     = 15;

  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_ONE  = 2'd1,
    CNT_TWO  = 2'd2,
    CNT_MORE = 2'd3
  } byte_cnt_e;

  typedef struct packed {
    logic [DIV_W-1:0] divider;
    logic [5:0]       filt;
    logic [4:0]       ratio;
    logic [1:0]       pump;
    logic [4:0]       refdiv;
    logic             pdown;
  } tuner_fields_t;

  // Power-up content of register (2 + idx)
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      0:  reg_default = 8'h00;
      1:  reg_default = 8'h00;
      2:  reg_default = 8'h80;
      3:  reg_default = 8'h00;
      4:  reg_default = 8'hC0;
      5:  reg_default = 8'h20;
      6:  reg_default = 8'hDB;
      7:  reg_default = 8'h30;
      8:  reg_default = 8'hE1;
      9:  reg_default = 8'hF5;
      10: reg_default = 8'hF0;
      11: reg_default = 8'h28;
      default: reg_default = 8'h00;
    endcase
  endfunction

  function automatic logic [IMG_W-1:0] default_image();
    logic [IMG_W-1:0] img;
    for (int i = 0; i < NUM_REGS; i++) img[i*REG_W +: REG_W] = reg_default(i);
    return img;
  endfunction

  // Byte k of the image holds register (2 + k)
  function automatic tuner_fields_t extract_fields(input logic [IMG_W-1:0] img);
    tuner_fields_t f;
    f.divider = {img[0*REG_W +: 7], img[1*REG_W +: 8]};
    f.filt    = img[5*REG_W + 1 +: 6];
    f.ratio   = img[11*REG_W + 2 +: 5];
    f.pdown   = img[11*REG_W + 7];
    f.pump    = img[3*REG_W + 5 +: 2];
    f.refdiv  = img[3*REG_W +: 5];
    return f;
  endfunction

endpackage

// File: rtl/tuner_prefix_decode.sv
module tuner_prefix_decode
  import tuner_pkg::*;
(
  input  logic [REG_W-1:0]  lead_i,
  output logic [PAIR_W-1:0] pair_o
);

  // Variable-length prefix: 1, 2 or 4 leading bits pick the pair
  always_comb begin
    casez (lead_i[7:4])
      4'b0???: pair_o = PAIR_W'(0);
      4'b10??: pair_o = PAIR_W'(1);
      4'b1100: pair_o = PAIR_W'(2);
      4'b1101: pair_o = PAIR_W'(3);
      4'b1110: pair_o = PAIR_W'(4);
      default: pair_o = PAIR_W'(5);
    endcase
  end

endmodule

// File: rtl/tuner_wr_seq.sv
module tuner_wr_seq
  import tuner_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic [REG_W-1:0] byte_i,
  input  logic             stop_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             done_o
);

  logic              active_q;
  byte_cnt_e         cnt_q;
  logic [PAIR_W-1:0] pair_q;
  logic [PAIR_W-1:0] pair_now;
  logic              accept;

  tuner_prefix_decode u_dec (
    .lead_i (byte_i),
    .pair_o (pair_now)
  );

  assign accept    = active_q && byte_vld_i;
  assign wr_data_o = byte_i;
  assign done_o    = stop_i && active_q && ((cnt_q != CNT_NONE) || byte_vld_i);

  always_comb begin
    wr_en_o  = 1'b0;
    wr_idx_o = '0;
    if (accept) begin
      if (cnt_q == CNT_NONE) begin
        wr_en_o  = 1'b1;
        wr_idx_o = {pair_now, 1'b0};
      end else if (cnt_q == CNT_ONE) begin
        wr_en_o  = 1'b1;
        wr_idx_o = {pair_q, 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= CNT_NONE;
      pair_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_NONE;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (accept) begin
      if (cnt_q == CNT_NONE) pair_q <= pair_now;
      if (cnt_q != CNT_MORE) cnt_q <= byte_cnt_e'(cnt_q + 2'd1);
    end
  end

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [IMG_W-1:0] image_o
);

  logic [REG_W-1:0] bank_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                      bank_q[g] <= reg_default(g);
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))  bank_q[g] <= wr_data_i;
    end
    assign image_o[g*REG_W +: REG_W] = bank_q[g];
  end

  // R1: first cycle out of reset shows the power-up content
  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (image_o == default_image()));

endmodule

// File: rtl/tuner_status.sv
module tuner_status
  import tuner_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_async_i,
  input  logic             done_i,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [REG_W-1:0] rd_data_o
);

  localparam int PAD_W = REG_W - 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lock_q;
  logic                   por_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], lock_async_i};
  end
  assign lock_q = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)         por_q <= 1'b1;
    else if (done_i) por_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) rd_data_o <= {por_q, lock_q, {PAD_W{1'b0}}};
    end
  end

  // R8: a request is answered on the following cycle
  assert_rd_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req_i |=> rd_valid_o);

  // R9: a completed write drops the power-on flag
  assert_por_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !por_q);

  // R9: once cleared, the flag never returns without reset
  assert_por_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !por_q |=> !por_q);

endmodule

// File: rtl/tuner_regfile.sv
module tuner_regfile
  import tuner_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_in,
  input  logic             xfer_start,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             xfer_stop,
  input  logic             status_req,
  output logic             status_valid,
  output logic [7:0]       status_data,
  output logic [95:0]      cfg_image,
  output logic [14:0]      divider,
  output logic [5:0]       filt_code,
  output logic [4:0]       ratio_code,
  output logic [1:0]       pump_code,
  output logic [4:0]       refdiv_code,
  output logic             power_down
);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;
  logic             done;
  tuner_fields_t    fld_q;

  tuner_wr_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (xfer_start),
    .byte_vld_i (byte_valid),
    .byte_i     (byte_data),
    .stop_i     (xfer_stop),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .done_o     (done)
  );

  tuner_reg_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .image_o   (cfg_image)
  );

  tuner_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
    .clk          (clk),
    .rst          (rst),
    .lock_async_i (lock_in),
    .done_i       (done),
    .rd_req_i     (status_req),
    .rd_valid_o   (status_valid),
    .rd_data_o    (status_data)
  );

  // Registered field decode (R11)
  always_ff @(posedge clk) begin
    if (rst) fld_q <= extract_fields(default_image());
    else     fld_q <= extract_fields(cfg_image);
  end

  assign divider     = fld_q.divider;
  assign filt_code   = fld_q.filt;
  assign ratio_code  = fld_q.ratio;
  assign pump_code   = fld_q.pump;
  assign refdiv_code = fld_q.refdiv;
  assign power_down  = fld_q.pdown;

  // R7 / R6: without a write strobe from the sequencer the image holds
  assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_image));

endmodule

// File: tb/tb_tuner_regfile.sv
module tb_tuner_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_in = 1'b0;
  logic        xfer_start = 1'b0, byte_valid = 1'b0, xfer_stop = 1'b0, status_req = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        status_valid;
  logic [7:0]  status_data;
  logic [95:0] cfg_image;
  logic [14:0] divider;
  logic [5:0]  filt_code;
  logic [4:0]  ratio_code;
  logic [1:0]  pump_code;
  logic [4:0]  refdiv_code;
  logic        power_down;

  always #2.5 clk = ~clk;

  tuner_regfile dut (
    .clk(clk), .rst(rst), .lock_in(lock_in),
    .xfer_start(xfer_start), .byte_valid(byte_valid), .byte_data(byte_data),
    .xfer_stop(xfer_stop), .status_req(status_req),
    .status_valid(status_valid), .status_data(status_data),
    .cfg_image(cfg_image), .divider(divider), .filt_code(filt_code),
    .ratio_code(ratio_code), .pump_code(pump_code),
    .refdiv_code(refdiv_code), .power_down(power_down)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] mdl [12];
  logic       por_m, lock_m;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    logic [7:0] d [12] = '{8'h00, 8'h00, 8'h80, 8'h00, 8'hC0, 8'h20,
                           8'hDB, 8'h30, 8'hE1, 8'hF5, 8'hF0, 8'h28};
    for (int i = 0; i < 12; i++) mdl[i] = d[i];
    por_m = 1'b1;
  endtask

  function automatic int pair_of(input logic [7:0] b);
    if (!b[7])      return 0;
    else if (!b[6]) return 1;
    else            return 2 + int'(b[5:4]);
  endfunction

  task automatic check_regs(input string tag);
    logic [95:0] img;
    logic [33:0] fexp, fact;
    for (int i = 0; i < 12; i++) img[i*8 +: 8] = mdl[i];
    check({tag, " image"}, cfg_image, img);
    fexp = {mdl[0][6:0], mdl[1], mdl[5][6:1], mdl[11][6:2], mdl[3][6:5], mdl[3][4:0], mdl[11][7]};
    fact = {divider, filt_code, ratio_code, pump_code, refdiv_code, power_down};
    check({tag, " R11 fields"}, 96'(fact), 96'(fexp));
  endtask

  // Driver: one transaction of n bytes, model updated per R2-R6, R9
  task automatic xfer(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] bs [3] = '{b0, b1, b2};
    int p;
    @(negedge clk) xfer_start = 1'b1;
    @(negedge clk) xfer_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = bs[i];
      @(negedge clk);
    end
    byte_valid = 1'b0; xfer_stop = 1'b1;
    @(negedge clk) xfer_stop = 1'b0;
    if (n >= 1) begin
      p = pair_of(b0);
      mdl[2*p] = b0;
      if (n >= 2) mdl[2*p+1] = b1;
      por_m = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  // Driver side of the scoreboard: push expected status, pulse request
  task automatic read_status(input string tag);
    exp_q.push_back({por_m, lock_m, 6'b0});
    tag_q.push_back(tag);
    @(negedge clk) status_req = 1'b1;
    @(negedge clk) status_req = 1'b0;
    @(negedge clk);
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && status_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected status actual=%h expected=none", status_data);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 96'(status_data), 96'(e));
      end
    end
  end

  initial begin
    lock_m = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_regs("R1 reset");
    read_status("R8 R9 status after reset");

    // R2 R3 R4: every pair with prefix-boundary first bytes
    xfer(2, 8'h7F, 8'hFF, 8'h00); check_regs("R2 R3 R4 pair 2/3 max divider");
    read_status("R9 por cleared after write");
    xfer(2, 8'hBF, 8'h6A, 8'h00); check_regs("R2 R4 pair 4/5");
    xfer(2, 8'hC0, 8'h7E, 8'h00); check_regs("R2 R4 pair 6/7");
    xfer(2, 8'hDF, 8'h11, 8'h00); check_regs("R2 pair 8/9");
    xfer(2, 8'hE0, 8'h5B, 8'h00); check_regs("R2 pair 10/11");
    xfer(2, 8'hF3, 8'hFC, 8'h00); check_regs("R2 R11 pair 12/13 power down");
    xfer(2, 8'h04, 8'h00, 8'h00); check_regs("R3 divider 0x400");

    // R5: single byte touches only the even register
    xfer(1, 8'hC8, 8'h00, 8'h00); check_regs("R5 one byte 0xC8");
    // R6: trailing byte ignored
    xfer(3, 8'h8B, 8'h0A, 8'hFF); check_regs("R6 three bytes");
    // R7: empty transaction and stray strobe
    xfer(0, 8'h00, 8'h00, 8'h00); check_regs("R7 empty transaction");
    @(negedge clk) begin byte_valid = 1'b1; byte_data = 8'h55; end
    @(negedge clk) byte_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_regs("R7 stray byte outside bracket");

    // R10: lock follows the input after synchronisation
    lock_in = 1'b1; lock_m = 1'b1;
    repeat (3) @(negedge clk);
    read_status("R10 lock high");
    lock_in = 1'b0; lock_m = 1'b0;
    repeat (3) @(negedge clk);
    read_status("R10 lock low");

    // R9: reset restores the power-on flag and defaults
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    check_regs("R1 second reset");
    read_status("R9 por after second reset");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R8 missing status actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule